// File: doc/BRIEF.md
# ADC Capture Sequencer

This block runs one successive-approximation converter whose conversion-start input and serial chip select share a single wire. A periodic trigger, programmed as a number of system clock cycles, starts each capture. Each capture first holds the select line low for a quiet interval. A rising edge then starts the conversion. The block clocks the result in MSB first on a serial clock that it generates, and it presents the result as a one-cycle valid pulse with a 32-bit word, zero-extended.

There are two read modes. In the after-conversion mode the line stays high for the whole conversion time with the serial clock idle, and the word is shifted in during acquisition, once the line is low again. In the during-conversion mode the line only pulses high for the minimum start width. The shift then begins at once and returns the result of the previous conversion. The cycle does not close until the conversion time has run out. A turbo input selects the shorter conversion time. All nanosecond limits are turned into clock counts, rounded up, from a clock period parameter. Mode, turbo and word length are latched when a trigger is accepted.

Top module: `adc_capture_seq`

## Requirements
- R1: Before every rising edge of `cs_o`, `cs_o` has been low for at least ceil(T_QUIET_NS/CLK_PERIOD_NS) cycles (1 cycle at defaults).
- R2: Every high phase of `cs_o` lasts at least ceil(T_CNVH_NS/CLK_PERIOD_NS) cycles (1 at defaults).
- R3: With `rd_during_i`=0 and `turbo_i`=0, `cs_o` is high for exactly ceil(CONV_NS/CLK_PERIOD_NS) cycles (21 at defaults). `sclk_o` never goes high while `cs_o` is high, and the word is shifted after `cs_o` falls.
- R4: With `rd_during_i`=1, `cs_o` is high for exactly the R2 minimum. The shift starts when `cs_o` falls and returns the word of the conversion before the current one. The next rising edge of `cs_o` comes at least QUIET+CONV cycles (22 at defaults) after the previous one.
- R5: With `turbo_i`=1 in after-conversion mode, `cs_o` is high for exactly ceil(TURBO_CONV_NS/CLK_PERIOD_NS) cycles (16 at defaults).
- R6: `sclk_o` idles low and gives exactly N rising edges per read, each bit taking 2 cycles. `sdi_i` is sampled on each rising edge, MSB first, so the first bit sampled lands in bit N-1 of the result.
- R7: `valid_o` is a one-cycle pulse, one per read. `data_o` carries the N received bits in bits N-1..0, with every bit above them zero.
- R8: Starts come every `period_i` cycles when the block is idle on each trigger; `period_i`=0 stops all triggers.
- R9: A trigger that arrives while a capture is active raises `overrun_o` for one cycle and starts nothing, so successive starts are a whole multiple of `period_i` apart.
- R10: During and right after reset, `cs_o`, `sclk_o`, `valid_o` and `overrun_o` are low.
- R11: N is `nbits_i`; a value of 0 or above MAX_BITS (18) is taken as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PERIOD_W | Sample period in clock cycles, 0 disables |
| rd_during_i | input | 1 | 1 selects reading during conversion |
| turbo_i | input | 1 | 1 selects the shorter conversion time |
| nbits_i | input | NB_W | Result width N |
| cs_o | output | 1 | Shared conversion start / chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data from the converter |
| valid_o | output | 1 | Result strobe |
| data_o | output | OUT_W | Zero-extended result |
| overrun_o | output | 1 | Trigger dropped while busy |

## Verification
The trigger tick and an active capture can fall in the same cycle. When they do, the tick must be dropped and flagged rather than restart the sequence. The bench provokes this with periods shorter than one capture, 30 cycles in after-conversion mode and 12 in during-conversion mode. It judges the result by the spacing of `cs_o` rising edges, by seeing overrun pulses, and by every start giving exactly one scoreboard result. The second overlap is the shift running inside the conversion window in during-conversion mode. A converter model swaps its held word at each start, and the scoreboard expects the older word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_QUIET,
    S_CONV,
    S_PULSE,
    S_READ,
    S_TAIL
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per_ns);
    int c;
    c = (ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_trig_gen.sv
module adc_trig_gen #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);

  logic [PERIOD_W-1:0] cnt_q;

  assign tick_o = (period_i != '0) && (cnt_q >= period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else if (period_i == '0)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int MAX_BITS = 18,
  parameter int NB_W     = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic                sdi_i,
  output logic                sclk_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o
);

  logic                busy_q, ph_q, sclk_q, done_q;
  logic [NB_W-1:0]     cnt_q;
  logic [MAX_BITS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
        sr_q   <= '0;
      end else if (busy_q) begin
        if (!ph_q) begin
          // rising edge of sclk: capture
          sclk_q <= 1'b1;
          sr_q   <= {sr_q[MAX_BITS-2:0], sdi_i};
          ph_q   <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          ph_q   <= 1'b0;
          if (cnt_q == nbits_i - 1'b1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign done_o = done_q;
  assign data_o = sr_q;

  p_sclk_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);

  p_one_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_QUIET_NS    = 20,
  parameter int T_CNVH_NS     = 10,
  parameter int CONV_NS       = 420,
  parameter int TURBO_CONV_NS = 320,
  parameter int MAX_BITS      = 18,
  parameter int OUT_W         = 32,
  parameter int PERIOD_W      = 32,
  parameter int NB_W          = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                rd_during_i,
  input  logic                turbo_i,
  input  logic [NB_W-1:0]     nbits_i,
  output logic                cs_o,
  output logic                sclk_o,
  input  logic                sdi_i,
  output logic                valid_o,
  output logic [OUT_W-1:0]    data_o,
  output logic                overrun_o
);

  localparam int QUIET_CYC = ns2cyc(T_QUIET_NS, CLK_PERIOD_NS);
  localparam int CNVH_CYC  = ns2cyc(T_CNVH_NS, CLK_PERIOD_NS);
  localparam int CONV_CYC  = ns2cyc(CONV_NS, CLK_PERIOD_NS);
  localparam int TURBO_CYC = ns2cyc(TURBO_CONV_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = (CONV_CYC > QUIET_CYC) ? CONV_CYC : QUIET_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1) + 1;

  seq_state_e          state_q;
  logic [TMR_W-1:0]    tmr_q, conv_q, conv_len;
  logic                mode_q, turbo_q, overrun_q;
  logic [NB_W-1:0]     nb_q;
  logic                tick, rx_start, rx_done;
  logic [MAX_BITS-1:0] rx_data;

  adc_trig_gen #(.PERIOD_W(PERIOD_W)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .tick_o  (tick)
  );

  assign conv_len = turbo_q ? TMR_W'(TURBO_CYC) : TMR_W'(CONV_CYC);
  assign rx_start = ((state_q == S_CONV) || (state_q == S_PULSE)) && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      tmr_q     <= '0;
      conv_q    <= '0;
      mode_q    <= 1'b0;
      turbo_q   <= 1'b0;
      nb_q      <= NB_W'(MAX_BITS);
      overrun_q <= 1'b0;
    end else begin
      overrun_q <= tick && (state_q != S_IDLE);
      if (conv_q != '0) conv_q <= conv_q - 1'b1;
      unique case (state_q)
        S_IDLE: if (tick) begin
          state_q <= S_QUIET;
          tmr_q   <= TMR_W'(QUIET_CYC - 1);
          mode_q  <= rd_during_i;
          turbo_q <= turbo_i;
          nb_q    <= ((nbits_i == '0) || (nbits_i > NB_W'(MAX_BITS)))
                     ? NB_W'(MAX_BITS) : nbits_i;
        end
        S_QUIET: if (tmr_q == '0) begin
          state_q <= mode_q ? S_PULSE : S_CONV;
          tmr_q   <= mode_q ? TMR_W'(CNVH_CYC - 1) : conv_len - 1'b1;
          conv_q  <= conv_len - 1'b1;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        S_CONV, S_PULSE: if (tmr_q == '0) state_q <= S_READ;
                         else tmr_q <= tmr_q - 1'b1;
        S_READ: if (rx_done) state_q <= mode_q ? S_TAIL : S_IDLE;
        S_TAIL: if (conv_q == '0) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  adc_shift_rx #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rx_start),
    .nbits_i(nb_q),
    .sdi_i  (sdi_i),
    .sclk_o (sclk_o),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  assign cs_o      = (state_q == S_CONV) || (state_q == S_PULSE);
  assign valid_o   = rx_done;
  assign data_o    = {{(OUT_W-MAX_BITS){1'b0}}, rx_data};
  assign overrun_o = overrun_q;

  // run-length counters for the select-line timing checks
  logic [7:0] lo_cnt, hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= cs_o ? '0 : ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !cs_o ? '0 : ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (lo_cnt >= 8'(QUIET_CYC)));

  p_cnvh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> (hi_cnt >= 8'(CNVH_CYC)));

  p_no_sclk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !sclk_o);

  p_zext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nb_q) == '0));

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> ($past(state_q) != S_IDLE));

endmodule

// File: tb/adc_capture_seq_test.sv
module adc_capture_seq_test;

  localparam int QUIET = 1, CNVH = 1, CONV = 21, TURBO = 16, MAXB = 18;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] period = '0;
  logic        during = 1'b0, turbo = 1'b0, sdi = 1'b0;
  logic [4:0]  nbits = 5'd16;
  logic        cs_o, sclk_o, valid_o, overrun_o;
  logic [31:0] data_o;

  int checks = 0, errors = 0;
  bit fin = 1'b0;

  adc_capture_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .rd_during_i(during),
    .turbo_i(turbo), .nbits_i(nbits), .cs_o(cs_o), .sclk_o(sclk_o),
    .sdi_i(sdi), .valid_o(valid_o), .data_o(data_o), .overrun_o(overrun_o)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nb_eff();
    return (nbits == 0 || nbits > MAXB) ? MAXB : int'(nbits);
  endfunction

  // scoreboard queue filled by the converter model
  logic [31:0] exp_q[$];

  // converter model: new conversion at each start, shifts on sclk falling
  logic [31:0] cur = 32'h0, prv = 32'h0, seed = 32'h1234_5677, tx = 32'h0;
  int bi = 0;
  bit m_cs = 1'b0;
  initial forever begin
    @(posedge cs_o or negedge cs_o or negedge sclk_o);
    if (cs_o && !m_cs) begin
      prv  = cur;
      cur  = seed;
      seed = seed * 32'd1103515245 + 32'd12345;
    end else if (!cs_o && m_cs) begin
      tx = during ? prv : cur;
      exp_q.push_back(tx & ((32'h1 << nb_eff()) - 1));
      bi  = nb_eff() - 1;
      sdi = tx[bi];
    end else if (!cs_o && !sclk_o) begin
      if (bi > 0) bi--;
      sdi = tx[bi];
    end
    m_cs = cs_o;
  end

  // monitor
  longint cyc = 0, last_rise = 0;
  bit have_rise = 0, cs_p = 0, sclk_p = 0, valid_p = 0;
  int hi_run = 0, lo_run = 0, sclk_n = 0, ovr_n = 0, rise_n = 0, res_n = 0;
  int sp_exact = 0, sp_min = 0;
  string sp_tag = "R8";

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cs_o) begin
      if (!cs_p) begin
        check(lo_run >= QUIET, "R1", lo_run, QUIET);
        if (have_rise && sp_exact != 0)
          check(cyc - last_rise == sp_exact, sp_tag, cyc - last_rise, sp_exact);
        if (have_rise && sp_min != 0)
          check(cyc - last_rise >= sp_min, "R4", cyc - last_rise, sp_min);
        have_rise = 1; last_rise = cyc; rise_n++; hi_run = 0;
      end
      hi_run++;
    end else begin
      if (cs_p) begin
        if (during)     check(hi_run == CNVH, "R4", hi_run, CNVH);
        else if (turbo) check(hi_run == TURBO, "R5", hi_run, TURBO);
        else            check(hi_run == CONV, "R3", hi_run, CONV);
        lo_run = 0;
      end
      lo_run++;
    end
    if (sclk_o && !sclk_p) begin
      check(!cs_o, "R3", cs_o, 0);
      sclk_n++;
    end
    if (overrun_o) ovr_n++;
    if (valid_o) begin
      check(!valid_p, "R7", valid_p, 0);
      check(sclk_n == nb_eff(), (nbits == 0) ? "R11" : "R6", sclk_n, nb_eff());
      if (exp_q.size() == 0) check(0, "R7", data_o, -1);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        check(data_o == e, during ? "R4" : "R7", data_o, e);
      end
      sclk_n = 0; res_n++;
    end
    cs_p = cs_o; sclk_p = sclk_o; valid_p = valid_o;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic run_phase(input int per, input bit dur, input bit tb, input int nb,
                           input int cycles, input int exact, input int minsp, input string tag);
    during = dur; turbo = tb; nbits = 5'(nb);
    sp_exact = exact; sp_min = minsp; sp_tag = tag; have_rise = 0;
    period = 32'(per);
    wait_cyc(cycles);
    period = '0;
    wait_cyc(150);
    sp_exact = 0; sp_min = 0;
  endtask

  initial begin
    int r0, o0;
    wait_cyc(3);
    @(negedge clk);
    // R10: outputs quiet in reset
    check(!cs_o && !sclk_o && !valid_o && !overrun_o, "R10",
          {cs_o, sclk_o, valid_o, overrun_o}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    @(negedge clk);
    check(!cs_o && !sclk_o && !valid_o && !overrun_o, "R10",
          {cs_o, sclk_o, valid_o, overrun_o}, 0);

    // R3/R8: after-conversion, normal time, exact period
    o0 = ovr_n;
    run_phase(100, 0, 0, 16, 450, 100, 0, "R8");
    check(ovr_n == o0, "R9", ovr_n - o0, 0);
    // R5: turbo
    run_phase(80, 0, 1, 14, 350, 80, 0, "R8");
    // R6: full width
    run_phase(90, 0, 0, 18, 300, 90, 0, "R8");
    // R11: zero width taken as maximum
    run_phase(90, 0, 0, 0, 300, 90, 0, "R8");
    // R4: during conversion, previous sample
    run_phase(60, 1, 0, 12, 400, 60, 22, "R8");
    // R4/R9: during conversion, period shorter than conversion
    o0 = ovr_n;
    run_phase(12, 1, 0, 4, 300, 0, 22, "R4");
    check(ovr_n > o0, "R9", ovr_n - o0, 1);
    // R9: after-conversion overrun, next start on the following tick
    o0 = ovr_n;
    run_phase(30, 0, 0, 16, 400, 60, 0, "R9");
    check(ovr_n > o0, "R9", ovr_n - o0, 1);
    // R8: period 0 disables
    r0 = rise_n;
    period = '0;
    wait_cyc(300);
    check(rise_n == r0, "R8", rise_n - r0, 0);

    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    check(res_n == rise_n, "R7", res_n, rise_n);
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule